// File: doc/BRIEF.md
# Ethernet PHY Management Register Responder

This block stands in for one Ethernet transceiver's management register set. A CPU writes a 32-bit management frame word; the block decodes it as a read or a write of one PHY register and completes the access on the next clock edge. For a read, the result replaces the low half of the frame register. For a write, the frame register keeps the word that was written. Every access ends with a one-cycle done pulse.

The register set holds control, status, advertisement, interrupt-source and interrupt-mask registers, plus four constant identity and capability registers. A link-level input is watched for edges. A change of link state updates the status link bits and latches an event into the interrupt sources. Interrupt sources clear when they are read. Setting the reset bit in the control register reloads the whole set and then refreshes the link state.

Top module: `mii_mgmt_responder`

## Requirements
- R1: After reset, control reads 0x3000, the advertisement register reads 0x01E1 and the interrupt mask reads 0x0000. Status reads 0x7809 with the link bits applied from the current link input (0x782D when the link is up). Interrupt sources read 0x00C0 when the link is up and 0x0010 when it is down. The frame register and the done output are zero.
- R2: Registers 2, 3, 5 and 6 read the constants 0x0007, 0xC0D1, 0x0F71 and 0x0001.
- R3: A falling edge on the link input clears status bits 5 and 2 and sets interrupt-source bit 4. A rising edge sets status bits 5 and 2 and sets interrupt-source bits 7 and 6. An edge is acted on at the clock edge that first samples the new level.
- R4: Reading register 29 returns the interrupt sources as they were, and clears them to zero.
- R5: A write to register 0 with bit 15 set reloads every register to its reset value. On the following clock edge the link state is applied again, as in R1.
- R6: A write to register 0 with bit 15 clear stores the data AND 0x7980 in control. If data bit 12 is set, status bit 5 is also set; status is otherwise left as it was.
- R7: A write to register 4 stores (data AND 0x2D7F) OR 0x0080. Advertisement bit 7 is therefore always one.
- R8: A write to register 30 stores data bits 7:0 as the interrupt mask. The upper eight bits of the mask always read zero.
- R9: Registers 17, 18, 27, 31 and every other address not named in R1 to R8 read zero and ignore writes. An address field value above 31 also reads zero and ignores writes.
- R10: In the frame word, bit 29 set selects a read, bits 27:18 hold the register address and bits 15:0 hold the write data. A read stores written bits 31:16 with the read result in bits 15:0. A write stores the written word unchanged.
- R11: The access takes effect at the clock edge that samples the strobe. The frame register, the registers and the done pulse all change at that edge. The done output is high for exactly the one cycle after each strobe and low otherwise.
- R12: While the link input holds steady, no link event is latched. After a read of register 29, a second read returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_wr | input | 1 | One-cycle write strobe for the frame register |
| frame_wdata | input | 32 | Management frame word being written |
| frame_rdata | output | 32 | Current frame register contents |
| link_up | input | 1 | Link level, one when the link is up |
| mgmt_done | output | 1 | One-cycle pulse when an access finishes |

## Verification
An access result is due one edge after the strobe: the strobe is raised at a falling edge and lowered at the next falling edge, and the frame register and done pulse are checked at that same falling edge. The done output is checked again one falling edge later, when it must be low. A change on the link input lands one edge after it is driven, and the reset-bit refresh lands one edge after the reset write. The bench therefore waits at least two cycles after either before it reads status or interrupt sources. Every expected value is derived from the masks and constants in the requirements, and the bench keeps its own copy of the control contents across scenarios.

// File: rtl/mii_mgmt_pkg.sv
package mii_mgmt_pkg;

    localparam int unsigned REG_W = 16;
    localparam int unsigned SEL_W = 5;

    typedef logic [REG_W-1:0] reg_word_t;
    typedef logic [SEL_W-1:0] reg_sel_t;

    // Register addresses that the block decodes
    localparam reg_sel_t SEL_CTRL  = 5'd0;
    localparam reg_sel_t SEL_STAT  = 5'd1;
    localparam reg_sel_t SEL_ID_HI = 5'd2;
    localparam reg_sel_t SEL_ID_LO = 5'd3;
    localparam reg_sel_t SEL_ADV   = 5'd4;
    localparam reg_sel_t SEL_PART  = 5'd5;
    localparam reg_sel_t SEL_EXPN  = 5'd6;
    localparam reg_sel_t SEL_ISRC  = 5'd29;
    localparam reg_sel_t SEL_IMASK = 5'd30;

    // Reset contents
    localparam reg_word_t CTRL_INIT = 16'h3000;
    localparam reg_word_t STAT_INIT = 16'h7809;
    localparam reg_word_t ADV_INIT  = 16'h01E1;

    // Write masks
    localparam reg_word_t CTRL_WMASK = 16'h7980;
    localparam reg_word_t ADV_WMASK  = 16'h2D7F;
    localparam reg_word_t ADV_FORCE  = 16'h0080;
    localparam reg_word_t IMASK_WMASK = 16'h00FF;

    // Control bit positions
    localparam int unsigned CTRL_RST_BIT = 15;
    localparam int unsigned CTRL_ANE_BIT = 12;

    // Status link bits, and the one set on autonegotiation enable
    localparam reg_word_t STAT_LINK_BITS = 16'h0024;
    localparam reg_word_t STAT_AN_DONE   = 16'h0020;

    // Interrupt source events
    localparam reg_word_t EVT_ENERGY  = 16'h0080;
    localparam reg_word_t EVT_AN_DONE = 16'h0040;
    localparam reg_word_t EVT_DOWN    = 16'h0010;

    typedef struct packed {
        reg_word_t ctrl;
        reg_word_t stat;
        reg_word_t adv;
        reg_word_t isrc;
        reg_word_t imask;
    } phy_regs_t;

    localparam phy_regs_t REGS_INIT = '{
        ctrl:  CTRL_INIT,
        stat:  STAT_INIT,
        adv:   ADV_INIT,
        isrc:  '0,
        imask: '0
    };

endpackage

// File: rtl/mii_frame_decode.sv
module mii_frame_decode
    import mii_mgmt_pkg::*;
#(
    parameter int unsigned FRAME_W  = 32,
    parameter int unsigned OP_BIT   = 29,
    parameter int unsigned ADDR_LSB = 18,
    parameter int unsigned ADDR_W   = 10
) (
    input  logic [FRAME_W-1:0] word,
    output logic               is_read,
    output reg_sel_t           sel,
    output logic               in_range,
    output reg_word_t          wr_val
);
    localparam int unsigned HI_W = ADDR_W - SEL_W;

    logic [ADDR_W-1:0] addr_field;

    assign addr_field = word[ADDR_LSB +: ADDR_W];
    assign is_read    = word[OP_BIT];
    assign sel        = addr_field[SEL_W-1:0];
    assign wr_val     = word[REG_W-1:0];

    generate
        if (HI_W > 0) begin : g_range
            assign in_range = (addr_field[ADDR_W-1:SEL_W] == '0);
        end else begin : g_full
            assign in_range = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/mii_link_tracker.sv
module mii_link_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic link_up,
    input  logic refresh_req,
    output logic upd_en,
    output logic upd_up
);
    typedef struct packed {
        logic prev;
        logic pend;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d      = trk_q;
        trk_d.prev = link_up;
        trk_d.pend = refresh_req;
        upd_en     = trk_q.pend | (link_up ^ trk_q.prev);
        upd_up     = link_up;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q.prev <= 1'b0;
            trk_q.pend <= 1'b1;
        end else begin
            trk_q <= trk_d;
        end
    end

endmodule

// File: rtl/mii_phy_regs.sv
module mii_phy_regs
    import mii_mgmt_pkg::*;
#(
    parameter reg_word_t ID_HI_VAL = 16'h0007,
    parameter reg_word_t ID_LO_VAL = 16'hC0D1,
    parameter reg_word_t PART_VAL  = 16'h0F71,
    parameter reg_word_t EXPN_VAL  = 16'h0001
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      acc_en,
    input  logic      acc_read,
    input  reg_sel_t  acc_sel,
    input  logic      acc_valid,
    input  reg_word_t acc_wdata,
    input  logic      upd_en,
    input  logic      upd_up,
    output reg_word_t rd_val,
    output logic      soft_rst,
    output phy_regs_t regs
);
    phy_regs_t regs_d, regs_q;

    // Read path, taken from the state before the access
    always_comb begin
        rd_val = '0;
        if (acc_valid) begin
            case (acc_sel)
                SEL_CTRL:  rd_val = regs_q.ctrl;
                SEL_STAT:  rd_val = regs_q.stat;
                SEL_ID_HI: rd_val = ID_HI_VAL;
                SEL_ID_LO: rd_val = ID_LO_VAL;
                SEL_ADV:   rd_val = regs_q.adv;
                SEL_PART:  rd_val = PART_VAL;
                SEL_EXPN:  rd_val = EXPN_VAL;
                SEL_ISRC:  rd_val = regs_q.isrc;
                SEL_IMASK: rd_val = regs_q.imask;
                default:   rd_val = '0;
            endcase
        end
    end

    // Next state: the access first, then any link update on top
    always_comb begin
        regs_d   = regs_q;
        soft_rst = 1'b0;
        if (acc_en && acc_valid) begin
            if (acc_read) begin
                if (acc_sel == SEL_ISRC) begin
                    regs_d.isrc = '0;
                end
            end else begin
                case (acc_sel)
                    SEL_CTRL: begin
                        if (acc_wdata[CTRL_RST_BIT]) begin
                            regs_d   = REGS_INIT;
                            soft_rst = 1'b1;
                        end else begin
                            regs_d.ctrl = acc_wdata & CTRL_WMASK;
                            if (acc_wdata[CTRL_ANE_BIT]) begin
                                regs_d.stat = regs_d.stat | STAT_AN_DONE;
                            end
                        end
                    end
                    SEL_ADV:   regs_d.adv   = (acc_wdata & ADV_WMASK) | ADV_FORCE;
                    SEL_IMASK: regs_d.imask = acc_wdata & IMASK_WMASK;
                    default: ;
                endcase
            end
        end
        if (upd_en) begin
            if (upd_up) begin
                regs_d.stat = regs_d.stat | STAT_LINK_BITS;
                regs_d.isrc = regs_d.isrc | EVT_ENERGY | EVT_AN_DONE;
            end else begin
                regs_d.stat = regs_d.stat & ~STAT_LINK_BITS;
                regs_d.isrc = regs_d.isrc | EVT_DOWN;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= REGS_INIT;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign regs = regs_q;

endmodule

// File: rtl/mii_mgmt_responder.sv
module mii_mgmt_responder
    import mii_mgmt_pkg::*;
#(
    parameter int unsigned FRAME_W   = 32,
    parameter int unsigned OP_BIT    = 29,
    parameter int unsigned ADDR_LSB  = 18,
    parameter int unsigned ADDR_W    = 10,
    parameter logic [15:0] ID_HI_VAL = 16'h0007,
    parameter logic [15:0] ID_LO_VAL = 16'hC0D1,
    parameter logic [15:0] PART_VAL  = 16'h0F71,
    parameter logic [15:0] EXPN_VAL  = 16'h0001
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_wr,
    input  logic [FRAME_W-1:0] frame_wdata,
    output logic [FRAME_W-1:0] frame_rdata,
    input  logic               link_up,
    output logic               mgmt_done
);
    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic               done;
    } top_state_t;

    top_state_t st_d, st_q;

    logic      dec_read;
    reg_sel_t  dec_sel;
    logic      dec_ok;
    reg_word_t dec_wval;
    reg_word_t rd_val;
    logic      soft_rst;
    logic      upd_en;
    logic      upd_up;
    phy_regs_t cur_regs;

    mii_frame_decode #(
        .FRAME_W  (FRAME_W),
        .OP_BIT   (OP_BIT),
        .ADDR_LSB (ADDR_LSB),
        .ADDR_W   (ADDR_W)
    ) u_decode (
        .word     (frame_wdata),
        .is_read  (dec_read),
        .sel      (dec_sel),
        .in_range (dec_ok),
        .wr_val   (dec_wval)
    );

    mii_link_tracker u_link (
        .clk         (clk),
        .rst_n       (rst_n),
        .link_up     (link_up),
        .refresh_req (soft_rst),
        .upd_en      (upd_en),
        .upd_up      (upd_up)
    );

    mii_phy_regs #(
        .ID_HI_VAL (ID_HI_VAL),
        .ID_LO_VAL (ID_LO_VAL),
        .PART_VAL  (PART_VAL),
        .EXPN_VAL  (EXPN_VAL)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_en    (frame_wr),
        .acc_read  (dec_read),
        .acc_sel   (dec_sel),
        .acc_valid (dec_ok),
        .acc_wdata (dec_wval),
        .upd_en    (upd_en),
        .upd_up    (upd_up),
        .rd_val    (rd_val),
        .soft_rst  (soft_rst),
        .regs      (cur_regs)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = frame_wr;
        if (frame_wr) begin
            if (dec_read) begin
                st_d.frame = {frame_wdata[FRAME_W-1:REG_W], rd_val};
            end else begin
                st_d.frame = frame_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign frame_rdata = st_q.frame;
    assign mgmt_done   = st_q.done;

endmodule

// File: rtl/mii_mgmt_responder_checker.sv
module mii_mgmt_responder_checker
    import mii_mgmt_pkg::*;
#(
    parameter int unsigned FRAME_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               frame_wr,
    input logic [FRAME_W-1:0] frame_wdata,
    input logic [FRAME_W-1:0] frame_rdata,
    input logic               mgmt_done,
    input logic               link_up,
    input logic               dec_read,
    input reg_sel_t           dec_sel,
    input logic               dec_ok,
    input logic               upd_en,
    input phy_regs_t          cur_regs
);

    assert_done_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
        frame_wr |=> mgmt_done);

    assert_done_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_wr |=> !mgmt_done);

    assert_link_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && link_up) |=>
            (cur_regs.stat[5] && cur_regs.stat[2] && cur_regs.isrc[7] && cur_regs.isrc[6]));

    assert_link_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !link_up) |=>
            (!cur_regs.stat[5] && !cur_regs.stat[2] && cur_regs.isrc[4]));

    assert_isrc_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_wr && dec_ok && dec_read && dec_sel == SEL_ISRC && !upd_en) |=>
            (cur_regs.isrc == '0));

    assert_adv_forced_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cur_regs.adv[7]);

    assert_mask_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cur_regs.imask[15:8] == 8'h00);

    assert_id_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_wr && dec_ok && dec_read && dec_sel == SEL_ID_LO) |=>
            (frame_rdata[15:0] == 16'hC0D1));

    assert_out_of_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_wr && !dec_ok && dec_read) |=> (frame_rdata[15:0] == 16'h0000));

    assert_write_echo_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_wr && !dec_read) |=> (frame_rdata == $past(frame_wdata)));

endmodule

bind mii_mgmt_responder mii_mgmt_responder_checker #(
    .FRAME_W (FRAME_W)
) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_wr    (frame_wr),
    .frame_wdata (frame_wdata),
    .frame_rdata (frame_rdata),
    .mgmt_done   (mgmt_done),
    .link_up     (link_up),
    .dec_read    (dec_read),
    .dec_sel     (dec_sel),
    .dec_ok      (dec_ok),
    .upd_en      (upd_en),
    .cur_regs    (cur_regs)
);

// File: tb/mii_mgmt_responder_test.sv
module mii_mgmt_responder_test;

    localparam int unsigned CLK_HALF = 5;
    localparam logic [31:0] RD_BASE = 32'h6003_BEEF;
    localparam logic [31:0] WR_BASE = 32'h5000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_wr = 1'b0;
    logic [31:0] frame_wdata = '0;
    logic [31:0] frame_rdata;
    logic        link_up = 1'b1;
    logic        mgmt_done;

    int n_checks = 0;
    int n_fails  = 0;
    logic [15:0] ctrl_model;

    mii_mgmt_responder uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_wr    (frame_wr),
        .frame_wdata (frame_wdata),
        .frame_rdata (frame_rdata),
        .link_up     (link_up),
        .mgmt_done   (mgmt_done)
    );

    always #CLK_HALF clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // One access; result and done sampled at the falling edge after the strobe edge
    task automatic access(input logic [31:0] word, output logic [31:0] result);
        @(negedge clk);
        frame_wr    = 1'b1;
        frame_wdata = word;
        @(negedge clk);
        frame_wr    = 1'b0;
        result      = frame_rdata;
        check("R11", "done after access", {31'b0, mgmt_done}, 32'd1);
    endtask

    task automatic phy_read(input logic [9:0] addr, output logic [15:0] val);
        logic [31:0] w, r;
        w = RD_BASE | ({22'b0, addr} << 18);
        access(w, r);
        check("R10", "read keeps upper half", {16'b0, r[31:16]}, {16'b0, w[31:16]});
        val = r[15:0];
    endtask

    task automatic phy_write(input logic [9:0] addr, input logic [15:0] data);
        logic [31:0] w, r;
        w = WR_BASE | ({22'b0, addr} << 18) | {16'b0, data};
        access(w, r);
        check("R10", "write echo", r, w);
    endtask

    task automatic expect_reg(input string req, input logic [9:0] addr, input logic [15:0] exp);
        logic [15:0] v;
        phy_read(addr, v);
        check(req, $sformatf("reg %0d", addr), {16'b0, v}, {16'b0, exp});
    endtask

    task automatic t_reset;
        check("R1", "frame after reset", frame_rdata, 32'h0);
        check("R1", "done after reset", {31'b0, mgmt_done}, 32'h0);
        cycles(2);
        expect_reg("R1", 10'd0, 16'h3000);
        expect_reg("R1", 10'd1, 16'h782D);
        expect_reg("R1", 10'd4, 16'h01E1);
        expect_reg("R1", 10'd30, 16'h0000);
        expect_reg("R1", 10'd29, 16'h00C0);
        ctrl_model = 16'h3000;
    endtask

    task automatic t_identity;
        expect_reg("R2", 10'd2, 16'h0007);
        expect_reg("R2", 10'd3, 16'hC0D1);
        expect_reg("R2", 10'd5, 16'h0F71);
        expect_reg("R2", 10'd6, 16'h0001);
    endtask

    task automatic t_isrc_steady;
        // R12: link steady, nothing new latched; R4: cleared by the earlier read
        cycles(4);
        expect_reg("R12", 10'd29, 16'h0000);
        expect_reg("R4", 10'd29, 16'h0000);
    endtask

    task automatic t_link;
        @(negedge clk) link_up = 1'b0;
        cycles(2);
        expect_reg("R3", 10'd1, 16'h7809);
        expect_reg("R3", 10'd29, 16'h0010);
        expect_reg("R4", 10'd29, 16'h0000);
        @(negedge clk) link_up = 1'b1;
        cycles(2);
        expect_reg("R3", 10'd1, 16'h782D);
        expect_reg("R3", 10'd29, 16'h00C0);
    endtask

    task automatic t_ctrl;
        @(negedge clk) link_up = 1'b0;
        cycles(2);
        expect_reg("R3", 10'd29, 16'h0010);
        phy_write(10'd0, 16'h1240);
        ctrl_model = 16'h1240 & 16'h7980;
        expect_reg("R6", 10'd0, ctrl_model);
        expect_reg("R6", 10'd1, 16'h7829);
        phy_write(10'd0, 16'h0180);
        ctrl_model = 16'h0180;
        expect_reg("R6", 10'd0, ctrl_model);
        expect_reg("R6", 10'd1, 16'h7829);
        @(negedge clk) link_up = 1'b1;
        cycles(2);
        expect_reg("R3", 10'd1, 16'h782D);
        expect_reg("R3", 10'd29, 16'h00C0);
    endtask

    task automatic t_adv;
        phy_write(10'd4, 16'hFFFF);
        expect_reg("R7", 10'd4, 16'h2DFF);
        phy_write(10'd4, 16'h0000);
        expect_reg("R7", 10'd4, 16'h0080);
    endtask

    task automatic t_mask;
        phy_write(10'd30, 16'hABCD);
        expect_reg("R8", 10'd30, 16'h00CD);
    endtask

    task automatic t_undef;
        phy_write(10'd17, 16'hFFFF);
        expect_reg("R9", 10'd17, 16'h0000);
        expect_reg("R9", 10'd18, 16'h0000);
        expect_reg("R9", 10'd27, 16'h0000);
        expect_reg("R9", 10'd31, 16'h0000);
        expect_reg("R9", 10'd7, 16'h0000);
        expect_reg("R9", 10'h041, 16'h0000);
        phy_write(10'h040, 16'h0000);
        expect_reg("R9", 10'd0, ctrl_model);
        phy_write(10'h044, 16'h0000);
        expect_reg("R9", 10'd4, 16'h0080);
    endtask

    task automatic t_soft_reset;
        phy_write(10'd0, 16'h8000);
        cycles(2);
        expect_reg("R5", 10'd0, 16'h3000);
        expect_reg("R5", 10'd4, 16'h01E1);
        expect_reg("R5", 10'd30, 16'h0000);
        expect_reg("R5", 10'd1, 16'h782D);
        expect_reg("R5", 10'd29, 16'h00C0);
        ctrl_model = 16'h3000;
    endtask

    task automatic t_timing;
        logic [15:0] v;
        cycles(1);
        check("R11", "done idle", {31'b0, mgmt_done}, 32'd0);
        phy_read(10'd2, v);
        check("R11", "result on strobe edge", {16'b0, v}, 32'h0007);
        @(negedge clk);
        check("R11", "done one cycle only", {31'b0, mgmt_done}, 32'd0);
        check("R11", "frame held", {16'b0, frame_rdata[15:0]}, 32'h0007);
    endtask

    initial begin
        cycles(3);
        rst_n = 1'b1;
        t_reset();
        t_identity();
        t_isrc_steady();
        t_link();
        t_ctrl();
        t_adv();
        t_mask();
        t_undef();
        t_soft_reset();
        t_timing();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(200000 * 2 * CLK_HALF);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule